// File: doc/BRIEF.md
# Four-Channel Timer with Pulse Accumulator

One 16-bit up-counter serves four capture/compare channels. The counter advances once every 2^n system clocks, where n is a 3-bit prescale field, so the divide ratio runs from 1 to 128. Each channel is set up on its own. In capture mode it latches the counter on a chosen edge of its pin. In compare mode it sets, clears or toggles its output when the counter reaches the channel value.

Channel 3 can be handed over to a 16-bit pulse accumulator. The accumulator has two modes. In event mode it counts the chosen edge of the channel-3 pin. In gated mode it counts 64-clock periods while that pin sits at its active level. When the main counter wraps it raises a flag, and software counts these flags to measure beyond 16 bits. The accumulator has an overflow flag of its own.

Every flag is sticky and is cleared by writing 1 to its bit. Each flag has its own enable, and the enabled flags are ORed onto one interrupt line. A flat register port handles all setup and status, with a write strobe and a combinational read. The pins are expected to be synchronous to the clock.

Register map, 4-bit address (unmapped addresses read 0):

- 0x0 control: bit 0 run, bits 3:1 prescale n.
- 0x1 accumulator setup: bit 0 enable, bit 1 gated mode, bit 2 polarity. In event mode the polarity picks the edge (0 rising, 1 falling). In gated mode it picks the gate level (0 active high, 1 active low).
- 0x2 accumulator count, read and write.
- 0x3 flags: bits 3:0 channels, bit 4 counter wrap, bit 5 accumulator overflow.
- 0x4 interrupt enables, same bit layout as the flags.
- 0x5 counter value, read only.
- 0x8+c channel c setup: bit 0 mode (0 capture, 1 compare), bits 2:1 select.
- 0xC+c channel c value.

Top module: `quad_timer_pacc`

## Requirements
- R1: After reset every register reads 0, oc_o is 0 and irq_o is 0.
- R2: While run is 1 the counter at address 0x5 increments once every 2^n clocks (n = control bits 3:1). While run is 0 the counter holds.
- R3: When the counter wraps from 0xFFFF to 0, flag bit 4 is set.
- R4: In compare mode, a channel acts on its output in the clock where the counter steps onto the channel value. The select field gives the action: 01 set, 10 clear, 11 toggle, 00 none. On the same clock the channel's flag bit is set.
- R5: In capture mode, a channel latches the counter value into its value register on the edge chosen by the select field (bit 1 rising, bit 2 falling) and sets its flag bit. A capture wins over a software write to the value register in the same clock.
- R6: Flags stay set until 1 is written to their bit at address 0x3. If a flag event and its clear fall in the same clock, the flag stays set.
- R7: With accumulator enable set, channel 3 produces no capture or compare events and oc_o[3] holds. In event mode the accumulator counts the edge chosen by the polarity bit on pin_i[3].
- R8: In gated mode the accumulator increments on every 64th clock after the mode is entered, provided pin_i[3] is at its active level on that clock. The 64-clock divider is held at zero outside gated mode.
- R9: When the accumulator wraps from 0xFFFF to 0, flag bit 5 is set. A software write to the count wins over an increment in the same clock and raises no overflow.
- R10: irq_o is 1 exactly when some flag bit and its enable bit at address 0x4 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| pin_i | input | 4 | Channel inputs; pin 3 also feeds the accumulator |
| oc_o | output | 4 | Compare outputs |
| irq_o | output | 1 | Combined interrupt |

## Verification
The counter-wrap flag is the hardest case to reach from the ports. It needs 65536 ticks, so the stimulus runs the counter undivided for a long stretch. The accumulator overflow is reached by preloading the count just below 0xFFFF, both before a burst of edges and before a gated interval. That gated interval is timed from the configuration write, so the exact number of 64-clock increments is known. Edge collisions between pin activity, flag clears and value writes come from a sparse pseudo-random pin pattern, and a behavioural model checks the result on every clock.

// File: rtl/quad_tmr_pkg.sv
package quad_tmr_pkg;
  localparam int AW = 4;
  localparam logic [AW-1:0] A_CTRL  = 4'h0;
  localparam logic [AW-1:0] A_PCFG  = 4'h1;
  localparam logic [AW-1:0] A_PCNT  = 4'h2;
  localparam logic [AW-1:0] A_FLAGS = 4'h3;
  localparam logic [AW-1:0] A_IEN   = 4'h4;
  localparam logic [AW-1:0] A_CNT   = 4'h5;
  localparam logic [AW-1:0] A_CHCFG = 4'h8;
  localparam logic [AW-1:0] A_CHVAL = 4'hC;

  typedef struct packed {
    logic [1:0] sel;
    logic       cmp;
  } chcfg_t;
endpackage

// File: rtl/tmr_base.sv
module tmr_base #(
  parameter int CNT_W      = 16,
  parameter int PRE_STAGES = 7,
  parameter int PSEL_W     = $clog2(PRE_STAGES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [PSEL_W-1:0] psel_i,
  output logic              tick_o,
  output logic              wrap_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  cnt_nxt_o
);
  logic [PRE_STAGES-1:0] pre_q, mask;
  logic [CNT_W-1:0]      cnt_q;

  always_comb begin
    for (int i = 0; i < PRE_STAGES; i++) mask[i] = (i < int'(psel_i));
  end

  assign tick_o    = run_i && ((pre_q & mask) == mask);
  assign cnt_nxt_o = cnt_q + 1'b1;
  assign wrap_o    = tick_o && (&cnt_q);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      if (run_i)  pre_q <= pre_q + 1'b1;
      if (tick_o) cnt_q <= cnt_nxt_o;
    end
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int CNT_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 active_i,
  input  quad_tmr_pkg::chcfg_t cfg_i,
  input  logic                 pin_i,
  input  logic                 tick_i,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic [CNT_W-1:0]     cnt_nxt_i,
  input  logic                 wr_i,
  input  logic [CNT_W-1:0]     wdata_i,
  output logic [CNT_W-1:0]     val_o,
  output logic                 oc_o,
  output logic                 event_o
);
  logic prev_q, oc_q;
  logic [CNT_W-1:0] val_q;
  logic rise, fall, cap_hit, cmp_hit;

  assign rise    = pin_i & ~prev_q;
  assign fall    = ~pin_i & prev_q;
  assign cap_hit = active_i & ~cfg_i.cmp & ((rise & cfg_i.sel[0]) | (fall & cfg_i.sel[1]));
  assign cmp_hit = active_i & cfg_i.cmp & tick_i & (cnt_nxt_i == val_q);
  assign event_o = cap_hit | cmp_hit;
  assign val_o   = val_q;
  assign oc_o    = oc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      oc_q   <= 1'b0;
      val_q  <= '0;
    end else begin
      prev_q <= pin_i;
      if (cap_hit)   val_q <= cnt_i;
      else if (wr_i) val_q <= wdata_i;
      if (cmp_hit) begin
        unique case (cfg_i.sel)
          2'b01:   oc_q <= 1'b1;
          2'b10:   oc_q <= 1'b0;
          2'b11:   oc_q <= ~oc_q;
          default: oc_q <= oc_q;
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr_pacc.sv
module tmr_pacc #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             gated_i,
  input  logic             pol_i,
  input  logic             pin_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic prev_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;
  logic edge_hit, gate_on, inc;

  // pol selects falling edge / active-low gate
  assign edge_hit = pol_i ? (~pin_i & prev_q) : (pin_i & ~prev_q);
  assign gate_on  = pin_i ^ pol_i;
  assign inc      = en_i & (gated_i ? (gate_on & (&div_q)) : edge_hit);
  assign ovf_o    = inc & ~wr_i & (&cnt_q);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      div_q  <= '0;
      cnt_q  <= '0;
    end else begin
      prev_q <= pin_i;
      div_q  <= (en_i && gated_i) ? div_q + 1'b1 : '0;
      if (wr_i)     cnt_q <= wdata_i;
      else if (inc) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/quad_timer_pacc.sv
module quad_timer_pacc
  import quad_tmr_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int PRE_STAGES = 7,
  parameter int NCH        = 4,
  parameter int GATE_DIV_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  input  logic [NCH-1:0]   pin_i,
  output logic [NCH-1:0]   oc_o,
  output logic             irq_o
);
  localparam int PSEL_W = $clog2(PRE_STAGES + 1);
  localparam int NFLG   = NCH + 2;
  localparam int PCH    = NCH - 1;

  logic              run_q;
  logic [PSEL_W-1:0] psel_q;
  logic              pen_q, pgate_q, ppol_q;
  logic [NFLG-1:0]   flags_q, ien_q, flag_ev, flag_clr;
  chcfg_t            cfg_q [NCH];
  logic [CNT_W-1:0]  val [NCH];
  logic [NCH-1:0]    ch_ev;
  logic              tick, wrap, pacc_ovf, wr_pcnt;
  logic [CNT_W-1:0]  cnt, cnt_nxt, pcnt;

  assign wr_pcnt  = we_i && (addr_i == A_PCNT);
  assign flag_clr = (we_i && (addr_i == A_FLAGS)) ? wdata_i[NFLG-1:0] : '0;
  assign flag_ev  = {pacc_ovf, wrap, ch_ev};

  tmr_base #(.CNT_W(CNT_W), .PRE_STAGES(PRE_STAGES), .PSEL_W(PSEL_W)) u_base (
    .clk_i, .rst_ni, .run_i(run_q), .psel_i(psel_q),
    .tick_o(tick), .wrap_o(wrap), .cnt_o(cnt), .cnt_nxt_o(cnt_nxt)
  );

  for (genvar g = 0; g < NCH; g++) begin : gen_ch
    tmr_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i, .rst_ni,
      .active_i (!((g == PCH) && pen_q)),
      .cfg_i    (cfg_q[g]),
      .pin_i    (pin_i[g]),
      .tick_i   (tick),
      .cnt_i    (cnt),
      .cnt_nxt_i(cnt_nxt),
      .wr_i     (we_i && (addr_i == (A_CHVAL | AW'(g)))),
      .wdata_i  (wdata_i),
      .val_o    (val[g]),
      .oc_o     (oc_o[g]),
      .event_o  (ch_ev[g])
    );
  end

  tmr_pacc #(.CNT_W(CNT_W), .DIV_W(GATE_DIV_W)) u_pacc (
    .clk_i, .rst_ni, .en_i(pen_q), .gated_i(pgate_q), .pol_i(ppol_q),
    .pin_i(pin_i[PCH]), .wr_i(wr_pcnt), .wdata_i(wdata_i),
    .cnt_o(pcnt), .ovf_o(pacc_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      psel_q  <= '0;
      pen_q   <= 1'b0;
      pgate_q <= 1'b0;
      ppol_q  <= 1'b0;
      ien_q   <= '0;
      flags_q <= '0;
      for (int i = 0; i < NCH; i++) cfg_q[i] <= '0;
    end else begin
      flags_q <= (flags_q & ~flag_clr) | flag_ev;
      if (we_i) begin
        if (addr_i == A_CTRL) begin
          run_q  <= wdata_i[0];
          psel_q <= wdata_i[PSEL_W:1];
        end
        if (addr_i == A_PCFG) begin
          pen_q   <= wdata_i[0];
          pgate_q <= wdata_i[1];
          ppol_q  <= wdata_i[2];
        end
        if (addr_i == A_IEN) ien_q <= wdata_i[NFLG-1:0];
        for (int i = 0; i < NCH; i++)
          if (addr_i == (A_CHCFG | AW'(i))) cfg_q[i] <= chcfg_t'(wdata_i[2:0]);
      end
    end
  end

  assign irq_o = |(flags_q & ien_q);

  always_comb begin
    rdata_o = '0;
    if (addr_i[3:2] == 2'b10)      rdata_o = CNT_W'(cfg_q[addr_i[1:0]]);
    else if (addr_i[3:2] == 2'b11) rdata_o = val[addr_i[1:0]];
    else begin
      unique case (addr_i)
        A_CTRL:  rdata_o = CNT_W'({psel_q, run_q});
        A_PCFG:  rdata_o = CNT_W'({ppol_q, pgate_q, pen_q});
        A_PCNT:  rdata_o = pcnt;
        A_FLAGS: rdata_o = CNT_W'(flags_q);
        A_IEN:   rdata_o = CNT_W'(ien_q);
        A_CNT:   rdata_o = cnt;
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int CNT_W = 16,
  parameter int NCH   = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             tick_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [NCH+1:0]   flags_i,
  input logic [NCH+1:0]   clr_i,
  input logic [CNT_W-1:0] pcnt_i,
  input logic             pwr_i,
  input logic [NCH+1:0]   ien_i,
  input logic             irq_i
);
  assert_cnt_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_i));

  assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (cnt_i == CNT_W'($past(cnt_i) + 1'b1)));

  assert_wrap_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (&cnt_i)) |=> flags_i[NCH]);

  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flags_i & $past(flags_i & ~clr_i)) == $past(flags_i & ~clr_i)));

  assert_pacc_ovf_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pcnt_i == '0) && ($past(pcnt_i) == {CNT_W{1'b1}}) && !$past(pwr_i)) |-> flags_i[NCH+1]);

  assert_irq_masked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_i == '0) |-> !irq_i);
endmodule

bind quad_timer_pacc tmr_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_q), .tick_i(tick), .cnt_i(cnt),
  .flags_i(flags_q), .clr_i(flag_clr), .pcnt_i(pcnt), .pwr_i(wr_pcnt),
  .ien_i(ien_q), .irq_i(irq_o)
);

// File: tb/sim_quad_timer_pacc.sv
`timescale 1ns/1ps
module sim_quad_timer_pacc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [3:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0] pin = '0;
  logic [3:0] oc;
  logic irq;
  logic pin_auto = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  int errors = 0, checks = 0, rot = 0;

  always #2.5 clk = ~clk;

  quad_timer_pacc u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin), .oc_o(oc), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_run, m_psel, m_pre, m_cnt, m_pen, m_pg, m_ppol, m_pcnt, m_pprev, m_div, m_flags, m_ien;
  int m_mode[4], m_sel[4], m_val[4], m_oc[4], m_prev[4];

  function automatic int exp_rd(input int a);
    case (a)
      0: return m_run | (m_psel << 1);
      1: return m_pen | (m_pg << 1) | (m_ppol << 2);
      2: return m_pcnt;
      3: return m_flags;
      4: return m_ien;
      5: return m_cnt;
      8, 9, 10, 11: return m_mode[a-8] | (m_sel[a-8] << 1);
      12, 13, 14, 15: return m_val[a-12];
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input int a);
    case (a)
      0, 5: return "R2";
      1: return "R7";
      2: return "R8";
      3: return "R6";
      4: return "R10";
      8, 9, 10, 11: return "R4";
      12, 13, 14, 15: return "R5";
      default: return "R1";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_psel = 0; m_pre = 0; m_cnt = 0; m_pen = 0; m_pg = 0; m_ppol = 0;
      m_pcnt = 0; m_pprev = 0; m_div = 0; m_flags = 0; m_ien = 0;
      for (int c = 0; c < 4; c++) begin
        m_mode[c] = 0; m_sel[c] = 0; m_val[c] = 0; m_oc[c] = 0; m_prev[c] = 0;
      end
    end else begin
      int mask, tick, ev, p, r, f, act, inc, pe, gate, clr, wd, a;
      wd = int'(wdata); a = int'(addr);
      mask = (1 << m_psel) - 1;
      tick = (m_run != 0) && ((m_pre & mask) == mask);
      ev = 0;
      if (tick && m_cnt == 65535) ev |= 16;
      for (int c = 0; c < 4; c++) begin
        act = !(c == 3 && m_pen != 0);
        p = int'(pin[c]);
        r = p && !m_prev[c];
        f = !p && m_prev[c];
        if (act && m_mode[c] == 1 && tick && ((m_cnt + 1) & 16'hFFFF) == m_val[c]) begin
          ev |= 1 << c;
          if (m_sel[c] == 1) m_oc[c] = 1;
          else if (m_sel[c] == 2) m_oc[c] = 0;
          else if (m_sel[c] == 3) m_oc[c] = 1 - m_oc[c];
        end
        if (act && m_mode[c] == 0 && ((r && (m_sel[c] & 1)) || (f && (m_sel[c] & 2)))) begin
          m_val[c] = m_cnt;
          ev |= 1 << c;
        end else if (we && a == 12 + c) m_val[c] = wd;
        m_prev[c] = p;
      end
      p = int'(pin[3]);
      pe = m_ppol ? (!p && m_pprev) : (p && !m_pprev);
      gate = (p != m_ppol);
      inc = m_pen && (m_pg ? (gate && m_div == 63) : pe);
      if (we && a == 2) m_pcnt = wd;
      else if (inc) begin
        if (m_pcnt == 65535) ev |= 32;
        m_pcnt = (m_pcnt + 1) & 16'hFFFF;
      end
      m_div = (m_pen && m_pg) ? (m_div + 1) % 64 : 0;
      m_pprev = p;
      clr = (we && a == 3) ? (wd & 63) : 0;
      m_flags = (m_flags & ~clr) | ev;
      if (tick) m_cnt = (m_cnt + 1) & 16'hFFFF;
      if (m_run) m_pre = (m_pre + 1) & 127;
      if (we) begin
        if (a == 0) begin m_run = wd & 1; m_psel = (wd >> 1) & 7; end
        if (a == 1) begin m_pen = wd & 1; m_pg = (wd >> 1) & 1; m_ppol = (wd >> 2) & 1; end
        if (a == 4) m_ien = wd & 63;
        if (a >= 8 && a <= 11) begin m_mode[a-8] = wd & 1; m_sel[a-8] = (wd >> 1) & 3; end
      end
      #1;
      for (int c = 0; c < 4; c++) chk("R4", oc[c], m_oc[c]);
      chk("R10", irq, ((m_flags & m_ien) != 0));
      chk(tag_of(a), rdata, exp_rd(a));
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (pin_auto && lfsr[7:5] == 3'b000) pin <= pin ^ lfsr[3:0];
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      we = 1'b0;
      rot = (rot + 1) % 16;
      addr = 4'(rot);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    we = 1'b1; addr = 4'(a); wdata = 16'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    @(negedge clk);
    we = 1'b0; addr = 4'(a);
    #0.5 v = rdata;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 16; a++) begin
      addr = 4'(a);
      #0.1 chk("R1", rdata, 0);
    end
    chk("R1", oc, 0);
    chk("R1", irq, 0);

    wr(4, 63);
    wr(8, 1 | (3 << 1));
    wr(12, 5);
    wr(9, 1 | (1 << 1));
    wr(13, 20);
    wr(10, 1 << 1);
    wr(11, 3 << 1);
    wr(0, 1);
    pin_auto = 1'b1;
    idle(300);
    wr(3, 63);
    idle(50);
    wr(0, 1 | (3 << 1));
    idle(400);
    wr(10, 2 << 1);
    wr(8, 1 | (2 << 1));
    wr(14, 16'h1234);
    idle(400);
    wr(0, 1 | (7 << 1));
    idle(600);
    wr(0, 0);
    idle(50);

    // long undivided run for the counter wrap
    wr(3, 63);
    wr(0, 1);
    idle(66000);
    rd(3, v);
    chk("R3", (v >> 4) & 1, 1);

    // accumulator, event mode, rising then falling
    pin_auto = 1'b0;
    @(negedge clk); pin = 4'b0000;
    wr(1, 1);
    wr(2, 16'hFFF0);
    idle(2);
    wr(3, 63);
    repeat (20) begin
      @(negedge clk); pin[3] = 1'b1;
      idle(1);
      @(negedge clk); pin[3] = 1'b0;
      idle(1);
    end
    rd(2, v);
    chk("R7", v, 16'h0004);
    rd(3, v);
    chk("R9", (v >> 5) & 1, 1);
    chk("R7", (v >> 3) & 1, 0);
    wr(1, 1 | 4);
    wr(2, 0);
    repeat (5) begin
      @(negedge clk); pin[3] = 1'b1;
      idle(2);
      @(negedge clk); pin[3] = 1'b0;
      idle(2);
    end
    rd(2, v);
    chk("R7", v, 5);

    // accumulator, gated mode
    @(negedge clk); pin[3] = 1'b1;
    wr(1, 0);
    wr(2, 16'hFFFE);
    wr(3, 63);
    wr(1, 1 | 2);
    idle(196);
    rd(2, v);
    chk("R8", v, 1);
    rd(3, v);
    chk("R9", (v >> 5) & 1, 1);
    wr(1, 1 | 2 | 4);
    idle(200);
    rd(2, v);
    chk("R8", v, 1);

    wr(4, 0);
    idle(2);
    chk("R10", irq, 0);
    idle(4);
    summary();
    $finish;
  end
endmodule